// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in packed BCD. A reference enable pulses once per period of a 32.768 kHz timebase. A prescaler counts those pulses and makes one tick per second. Each tick moves the seconds on, and the carries ripple through minutes, hours, date, month and year. A day-of-week counter steps with every change of date. Month lengths are handled, and so are leap years for the two-digit years 00 to 99, which mean 2000 to 2099.

A host loads any single field through a simple write port. Every write restarts the prescaler, so the first tick after a write comes a full second later. A read request takes all fields into a snapshot register on one clock edge. The host then sees a coherent set of values even when a carry happens on that same edge.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the time is 00:00:00, date 01, month 01, year 00, day-of-week 0, and rd_valid is low.
- R2: After every TICK_DIV cycles with ref_en high, the seconds advance by one, in BCD.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R4: Hours count in 24-hour form. They wrap from 23 to 00 and carry into the date and the day-of-week.
- R5: Months 04, 06, 09 and 11 have 30 days, and every other month except February has 31. After the last day the date becomes 01 and the month advances.
- R6: February has 29 days when the year value (00 to 99) is divisible by 4, and 28 days otherwise.
- R7: On a rollover from month 12 the month becomes 01 and the year advances. Year 99 wraps to 00.
- R8: The day-of-week counts 0 to 6, wraps from 6 to 0, and changes only when the date rolls over.
- R9: A high wr_en loads wr_data into the field chosen by wr_sel (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day-of-week from wr_data[2:0]). A write has priority over a tick in the same cycle and clears the prescaler.
- R10: rd_req captures every field as it stood before that clock edge. rd_valid is high in the next cycle only, and the snapshot holds until the next rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One pulse per reference period |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | BCD write data |
| rd_req | input | 1 | Snapshot request |
| rd_valid | output | 1 | Snapshot was taken on the previous edge |
| rd_sec | output | 8 | Snapshot seconds (BCD) |
| rd_min | output | 8 | Snapshot minutes (BCD) |
| rd_hour | output | 8 | Snapshot hours (BCD) |
| rd_date | output | 8 | Snapshot date (BCD) |
| rd_month | output | 8 | Snapshot month (BCD) |
| rd_year | output | 8 | Snapshot year (BCD) |
| rd_dow | output | 3 | Snapshot day-of-week |

## Verification
The hardest cases to reach from the ports are the month-end and year-end rollovers. In normal counting these are months of seconds apart. The bench gets there directly: it writes a time of 23:59:59 and a date one day short of, or equal to, the month length. It does this for every month across a set of years that covers leap years, non-leap years and the wrap from 99. The prescaler is shortened to four reference pulses so that each case costs only a few cycles.

The coherent snapshot is reached by raising rd_req on the exact edge that carries 12:59:59 into the next hour. The bench then checks that the captured fields all come from the time before that edge.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic [2:0] dow;
    } cal_t;

    localparam logic [2:0] SEL_SEC   = 3'd0;
    localparam logic [2:0] SEL_MIN   = 3'd1;
    localparam logic [2:0] SEL_HOUR  = 3'd2;
    localparam logic [2:0] SEL_DATE  = 3'd3;
    localparam logic [2:0] SEL_MONTH = 3'd4;
    localparam logic [2:0] SEL_YEAR  = 3'd5;
    localparam logic [2:0] SEL_DOW   = 3'd6;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (ref_en) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ref_en && !restart));
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [6:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        leap     = (year_bin[1:0] == 2'b00);
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int TICK_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_sec,
    output logic [7:0] rd_min,
    output logic [7:0] rd_hour,
    output logic [7:0] rd_date,
    output logic [7:0] rd_month,
    output logic [7:0] rd_year,
    output logic [2:0] rd_dow
);
    typedef struct packed {
        cal_t now;
        cal_t snap;
        logic vld;
    } core_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   date: 8'h01, month: 8'h01, year: 8'h00,
                                   dow: 3'd0};

    core_t st_d, st_q;
    logic  tick;
    logic  [7:0] last_date;
    logic  c_sec, c_min, c_hour, c_date, c_month;

    cal_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(wr_en), .tick(tick)
    );

    cal_month_len u_len (
        .month(st_q.now.month), .year(st_q.now.year), .last_date(last_date)
    );

    always_comb begin
        c_sec   = (st_q.now.sec  >= 8'h59);
        c_min   = c_sec  && (st_q.now.min  >= 8'h59);
        c_hour  = c_min  && (st_q.now.hour >= 8'h23);
        c_date  = c_hour && (st_q.now.date >= last_date);
        c_month = c_date && (st_q.now.month >= 8'h12);

        st_d     = st_q;
        st_d.vld = rd_req;
        if (rd_req) st_d.snap = st_q.now;

        if (wr_en) begin
            case (wr_sel)
                SEL_SEC:   st_d.now.sec   = wr_data;
                SEL_MIN:   st_d.now.min   = wr_data;
                SEL_HOUR:  st_d.now.hour  = wr_data;
                SEL_DATE:  st_d.now.date  = wr_data;
                SEL_MONTH: st_d.now.month = wr_data;
                SEL_YEAR:  st_d.now.year  = wr_data;
                SEL_DOW:   st_d.now.dow   = wr_data[2:0];
                default:   st_d.now       = st_q.now;
            endcase
        end else if (tick) begin
            st_d.now.sec = c_sec ? 8'h00 : bcd_inc(st_q.now.sec);
            if (c_sec) st_d.now.min = c_min ? 8'h00 : bcd_inc(st_q.now.min);
            if (c_min) st_d.now.hour = c_hour ? 8'h00 : bcd_inc(st_q.now.hour);
            if (c_hour) begin
                st_d.now.date = c_date ? 8'h01 : bcd_inc(st_q.now.date);
                st_d.now.dow  = (st_q.now.dow >= 3'd6) ? 3'd0 : st_q.now.dow + 3'd1;
            end
            if (c_date) st_d.now.month = c_month ? 8'h01 : bcd_inc(st_q.now.month);
            if (c_month) st_d.now.year = (st_q.now.year >= 8'h99) ? 8'h00
                                                                   : bcd_inc(st_q.now.year);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.now  <= CAL_RESET;
            st_q.snap <= CAL_RESET;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.vld;
    assign rd_sec   = st_q.snap.sec;
    assign rd_min   = st_q.snap.min;
    assign rd_hour  = st_q.snap.hour;
    assign rd_date  = st_q.snap.date;
    assign rd_month = st_q.snap.month;
    assign rd_year  = st_q.snap.year;
    assign rd_dow   = st_q.snap.dow;

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.now.sec == 8'h59) |=> (st_q.now.sec == 8'h00));
    // R8
    dow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(tick && st_q.now.hour == 8'h23 && st_q.now.min == 8'h59
                     && st_q.now.sec == 8'h59)) |=> $stable(st_q.now.dow));
    // R6
    feb_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && c_hour && st_q.now.month == 8'h02 && st_q.now.date == 8'h28
         && (st_q.now.year == 8'h00 || st_q.now.year == 8'h04 || st_q.now.year == 8'h96))
        |=> (st_q.now.date == 8'h29));
    // R10
    snap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && $stable(rd_sec) && $stable(rd_date) && $stable(rd_year)));
endmodule

// File: tb/sim_cal_clock_core.sv
module sim_cal_clock_core;
    localparam int DIV = 4;

    logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b0, wr_en = 1'b0, rd_req = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       rd_valid;
    logic [7:0] rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year;
    logic [2:0] rd_dow;

    int errs = 0, checks = 0;
    int s, m, h, dd, mo, y, dw;

    always #5 clk = ~clk;

    cal_clock_core #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_sec(rd_sec),
        .rd_min(rd_min), .rd_hour(rd_hour), .rd_date(rd_date), .rd_month(rd_month),
        .rd_year(rd_year), .rd_dow(rd_dow)
    );

    function automatic logic [7:0] tobcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [50:0] expv();
        return {tobcd(s), tobcd(m), tobcd(h), tobcd(dd), tobcd(mo), tobcd(y), 3'(dw)};
    endfunction

    function automatic logic [50:0] actv();
        return {rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year, rd_dow};
    endfunction

    task automatic chk(input string tag, input logic [50:0] act, input logic [50:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = (sel == 3'd6) ? 8'(val) : tobcd(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_en = 1'b1;
        end
        @(negedge clk);
        ref_en = 1'b0;
    endtask

    task automatic load_all();
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dd);
        wr(3'd4, mo); wr(3'd5, y); wr(3'd6, dw);
    endtask

    task automatic model_tick();
        s++;
        if (s == 60) begin s = 0; m++; end
        if (m == 60) begin m = 0; h++; end
        if (h == 24) begin
            h = 0; dd++; dw = (dw + 1) % 7;
            if (dd > dim(mo, y)) begin dd = 1; mo++; end
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int years[7] = '{0, 1, 2, 3, 4, 96, 99};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_valid low", 51'(rd_valid), 51'd0);
        rd();
        chk("R10 rd_valid after request", 51'(rd_valid), 51'd1);
        s = 0; m = 0; h = 0; dd = 1; mo = 1; y = 0; dw = 0;
        chk("R1 reset time", actv(), expv());
        @(negedge clk);
        chk("R10 rd_valid one cycle", 51'(rd_valid), 51'd0);

        // R2 R3: seconds sweep over an hour boundary
        s = 40; m = 58; h = 0; dd = 9; mo = 3; y = 21; dw = 2;
        load_all();
        for (int i = 0; i < 3700; i++) begin
            pulses(DIV);
            model_tick();
            rd();
            chk("R2 R3 R8 seconds sweep", actv(), expv());
        end

        // R9: write clears prescaler; write beats a tick
        pulses(2);
        s = 10; wr(3'd0, 10);
        pulses(DIV - 1);
        rd();
        chk("R9 no tick before full second", actv(), expv());
        pulses(1);
        model_tick();
        rd();
        chk("R9 tick after full second", actv(), expv());

        // R10: snapshot on the carry edge is coherent
        s = 59; m = 59; h = 12; load_all();
        pulses(DIV - 1);
        @(negedge clk);
        ref_en = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        ref_en = 1'b0; rd_req = 1'b0;
        chk("R10 snapshot before carry", actv(), expv());
        pulses(DIV * 2);
        chk("R10 snapshot held", actv(), expv());
        model_tick(); model_tick(); model_tick();
        rd();
        chk("R10 R4 after carry", actv(), expv());

        // R4..R8: month and year ends
        foreach (years[k]) begin
            for (int mon = 1; mon <= 12; mon++) begin
                for (int last = 0; last < 2; last++) begin
                    s = 59; m = 59; h = 23; mo = mon; y = years[k];
                    dd = dim(mon, y) - 1 + last; dw = (mon + last) % 7;
                    load_all();
                    pulses(DIV);
                    model_tick();
                    rd();
                    chk(last ? "R5 R6 R7 R8 month end" : "R4 R5 R6 day before end",
                        actv(), expv());
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule